// File: doc/BRIEF.md
# Banked Nibble-Wide Calendar Clock with Alarm

This block is a real-time calendar clock that a host reaches through a 4-bit address and a 4-bit data path. It keeps seconds, minutes, hours, a weekday, the day of the month, the month and a four-digit year. Each value is held as a separate BCD digit register. Time moves forward by one second on every single-cycle pulse of a 1 Hz tick input. The day count follows the month length and the Gregorian leap-year rule.

The address space is split into banks. A control nibble at the top address can be seen from every bank. It selects the bank, holds a stop bit that freezes counting while software loads the time, and shows a busy bit for a fixed number of clock cycles after each second update. Bank 0 holds the time digits. Bank 1 holds the alarm digits, each pair with its own ignore bit, plus an alarm control nibble that holds the enable and a sticky flag; an interrupt output is driven from these two bits. Bank 2 holds a plain read/write timer control nibble.

Reads are combinational from the address, so the data is valid in the same cycle. Writes take effect at the rising clock edge while the write enable is high.

Top module: `nibble_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, weekday 0, day 01, month 01, year 0000. The control nibble reads 0 (bank 0, running, not busy), and the interrupt output is low.
- R2: Bank 0 digit map: 0 sec units, 1 sec tens, 2 min units, 3 min tens, 4 hour units, 5 hour tens, 6 weekday, 7 day units, 8 day tens, 9 month units, 10 month tens, 11..14 year units, tens, hundreds, thousands. A host write to one of these addresses while not busy is stored and read back.
- R3: While the stop bit (control bit 1) is 1, a tick does not change any time digit and does not raise busy.
- R4: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00, and hour units carry into hour tens after 9.
- R5: The day wraps to 01 after the last day of the month (30 for months 4, 6, 9, 11; 31 for the rest). The month wraps from 12 to 01 and carries into the year. Year 9999 wraps to 0000.
- R6: February has 29 days when the year is divisible by 4 and not by 100, or when it is divisible by 400. Otherwise it has 28.
- R7: The weekday advances on each new day and wraps from 6 to 0.
- R8: Busy (control bit 0) is 1 for exactly BUSY_CYCLES clock cycles after each tick that advances the time. It is 0 otherwise.
- R9: A host write to a bank 0 time digit is ignored while busy is 1.
- R10: On a tick, the alarm flag sets when every alarm field whose ignore bit (bit 3 of the seconds-tens, minutes-tens, hours-tens, weekday and day-tens alarm registers) is 0 equals the new time. Alarm registers sit at bank 1 addresses 0..8 with the same layout as bank 0.
- R11: The alarm control nibble is at bank 1 address 14: bit 0 is enable, bit 1 is flag. Writing 0 to bit 1 clears the flag, and writing 1 leaves it unchanged. The interrupt output is high exactly while flag and enable are both 1.
- R12: The control nibble at address 15 is read and written identically in every bank. Bits 3:2 select the bank. Writes to alarm or timer addresses never change the time digits.
- R13: Bank 2 address 14 is a 2-bit read/write timer control (bit 0 enable, bit 1 flag). Every unmapped address in banks 1..3 reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data for addr_i in the current bank (combinational) |
| irq_o | output | 1 | Alarm interrupt, high while flag and enable are set |

## Verification
Read data follows the address in the same cycle. The bench therefore drives the address on a falling edge and samples it 1 ns after the following rising edge, with no write or tick in that cycle. A tick driven before rising edge E0 has updated the digits, the alarm flag, the interrupt and busy by E0. So the first check after a tick samples just after E1. Busy is expected high at the samples after E1, E2 and E3 and low after E4 (BUSY_CYCLES = 4). A write issued in the cycle right after a tick lands at E1 while busy, so it must be dropped. Each expected value is queued by the driver in the cycle its sample is due and popped by the monitor at that sample.

// File: rtl/rtcn_pkg.sv
package rtcn_pkg;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 4;
  localparam int N_DIG  = 15;
  localparam int N_ALM  = 9;

  typedef logic [NIB_W-1:0] nib_t;
  typedef nib_t [N_DIG-1:0] cal_t;
  typedef nib_t [N_ALM-1:0] alm_t;

  // digit positions inside the calendar bank; the host decodes them
  localparam int IX_SU  = 0;
  localparam int IX_ST  = 1;
  localparam int IX_MU  = 2;
  localparam int IX_MT  = 3;
  localparam int IX_HU  = 4;
  localparam int IX_HT  = 5;
  localparam int IX_WD  = 6;
  localparam int IX_DU  = 7;
  localparam int IX_DT  = 8;
  localparam int IX_MOU = 9;
  localparam int IX_MOT = 10;
  localparam int IX_Y0  = 11;
  localparam int IX_Y1  = 12;
  localparam int IX_Y2  = 13;
  localparam int IX_Y3  = 14;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'hF;
  localparam logic [ADDR_W-1:0] A_FLAGS = 4'hE;

  // control nibble fields
  localparam int CB_BUSY = 0;
  localparam int CB_STOP = 1;
  localparam int CB_BANK = 2;
  // alarm / timer control fields
  localparam int FB_EN   = 0;
  localparam int FB_FLAG = 1;
  // ignore bit inside alarm tens / weekday registers
  localparam int DC_BIT  = 3;

  typedef struct packed {
    logic carry;
    nib_t tens;
    nib_t units;
  } pair_t;

  function automatic logic [7:0] bcd_val(input nib_t t, input nib_t u);
    return 8'(t) * 8'd10 + 8'(u);
  endfunction

  // step a two-digit BCD field; wrap to 'first' after 'last'
  function automatic pair_t pair_step(input nib_t t, input nib_t u,
                                      input logic [7:0] last, input logic [7:0] first);
    logic [7:0] v;
    pair_t r;
    v = bcd_val(t, u);
    if (v >= last) begin
      v = first;
      r.carry = 1'b1;
    end else begin
      v = v + 8'd1;
      r.carry = 1'b0;
    end
    r.tens  = 4'(v / 8'd10);
    r.units = 4'(v % 8'd10);
    return r;
  endfunction

  function automatic logic is_leap(input cal_t c);
    logic [7:0] lo, hi;
    lo = bcd_val(c[IX_Y1], c[IX_Y0]);
    hi = bcd_val(c[IX_Y3], c[IX_Y2]);
    return (lo == 8'd0) ? (hi[1:0] == 2'd0) : (lo[1:0] == 2'd0);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
    case (mon)
      8'd2:                      return leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction

  function automatic nib_t write_mask(input int idx);
    case (idx)
      IX_ST, IX_MT, IX_WD: return 4'h7;
      IX_HT, IX_DT:        return 4'h3;
      IX_MOT:              return 4'h1;
      default:             return 4'hF;
    endcase
  endfunction

  function automatic cal_t cal_reset();
    cal_t r;
    r = '0;
    r[IX_DU]  = 4'd1;
    r[IX_MOU] = 4'd1;
    return r;
  endfunction

  function automatic cal_t cal_advance(input cal_t c);
    cal_t n;
    pair_t s, m, h, d, mo;
    logic cy;
    n  = c;
    m  = '0;
    h  = '0;
    d  = '0;
    mo = '0;
    s = pair_step(c[IX_ST], c[IX_SU], 8'd59, 8'd0);
    n[IX_ST] = s.tens;
    n[IX_SU] = s.units;
    if (s.carry) begin
      m = pair_step(c[IX_MT], c[IX_MU], 8'd59, 8'd0);
      n[IX_MT] = m.tens;
      n[IX_MU] = m.units;
      if (m.carry) begin
        h = pair_step(c[IX_HT], c[IX_HU], 8'd23, 8'd0);
        n[IX_HT] = h.tens;
        n[IX_HU] = h.units;
        if (h.carry) begin
          n[IX_WD] = (c[IX_WD] >= 4'd6) ? 4'd0 : c[IX_WD] + 4'd1;
          d = pair_step(c[IX_DT], c[IX_DU],
                        month_len(bcd_val(c[IX_MOT], c[IX_MOU]), is_leap(c)), 8'd1);
          n[IX_DT] = d.tens;
          n[IX_DU] = d.units;
          if (d.carry) begin
            mo = pair_step(c[IX_MOT], c[IX_MOU], 8'd12, 8'd1);
            n[IX_MOT] = mo.tens;
            n[IX_MOU] = mo.units;
            if (mo.carry) begin
              cy = 1'b1;
              for (int i = IX_Y0; i <= IX_Y3; i++) begin
                if (cy) begin
                  if (c[i] >= 4'd9) n[i] = 4'd0;
                  else begin
                    n[i] = c[i] + 4'd1;
                    cy   = 1'b0;
                  end
                end
              end
            end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic logic alarm_hit(input alm_t a, input cal_t c);
    logic ok;
    ok = 1'b1;
    if (!a[IX_ST][DC_BIT])
      ok &= (a[IX_SU] == c[IX_SU]) && (a[IX_ST][2:0] == c[IX_ST][2:0]);
    if (!a[IX_MT][DC_BIT])
      ok &= (a[IX_MU] == c[IX_MU]) && (a[IX_MT][2:0] == c[IX_MT][2:0]);
    if (!a[IX_HT][DC_BIT])
      ok &= (a[IX_HU] == c[IX_HU]) && (a[IX_HT][2:0] == c[IX_HT][2:0]);
    if (!a[IX_WD][DC_BIT])
      ok &= (a[IX_WD][2:0] == c[IX_WD][2:0]);
    if (!a[IX_DT][DC_BIT])
      ok &= (a[IX_DU] == c[IX_DU]) && (a[IX_DT][2:0] == c[IX_DT][2:0]);
    return ok;
  endfunction
endpackage

// File: rtl/rtcn_ctrl.sv
module rtcn_ctrl
  import rtcn_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_i,
  input  nib_t       wdata_i,
  output logic [1:0] bank_o,
  output logic       stop_o,
  output logic       busy_o,
  output logic       advance_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign advance_o = tick_i && !stop_o;
  assign busy_o    = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= 2'd0;
      stop_o <= 1'b0;
    end else if (wr_i) begin
      bank_o <= wdata_i[CB_BANK +: 2];
      stop_o <= wdata_i[CB_STOP];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (advance_o) cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (busy_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rtcn_calendar.sv
module rtcn_calendar
  import rtcn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  nib_t              wdata_i,
  output cal_t              cal_o,
  output cal_t              cal_next_o
);
  cal_t cal_q;
  cal_t wmask;

  for (genvar g = 0; g < N_DIG; g++) begin : g_mask
    assign wmask[g] = write_mask(g);
  end

  assign cal_next_o = cal_advance(cal_q);
  assign cal_o      = cal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cal_q <= cal_reset();
    else if (advance_i) cal_q <= cal_next_o;
    else if (wr_i && (waddr_i < ADDR_W'(N_DIG)))
      cal_q[waddr_i] <= wdata_i & wmask[waddr_i];
  end
endmodule

// File: rtl/rtcn_alarm.sv
module rtcn_alarm
  import rtcn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  input  logic              wr_reg_i,
  input  logic              wr_ctl_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  nib_t              wdata_i,
  input  cal_t              cal_next_i,
  output alm_t              alm_o,
  output logic              aie_o,
  output logic              aflag_o,
  output logic              hit_o
);
  alm_t alm_q;

  assign alm_o = alm_q;
  assign hit_o = alarm_hit(alm_q, cal_next_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alm_q <= '0;
    else if (wr_reg_i && (waddr_i < ADDR_W'(N_ALM))) alm_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aie_o   <= 1'b0;
      aflag_o <= 1'b0;
    end else begin
      if (wr_ctl_i) aie_o <= wdata_i[FB_EN];
      if (advance_i && hit_o) aflag_o <= 1'b1;
      else if (wr_ctl_i && !wdata_i[FB_FLAG]) aflag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/nibble_rtc.sv
module nibble_rtc
  import rtcn_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [3:0] addr_i,
  input  logic       wr_en_i,
  input  logic [3:0] wdata_i,
  output logic [3:0] rdata_o,
  output logic       irq_o
);
  logic [1:0] bank;
  logic       stop, busy, advance;
  logic       wr_ctrl, wr_cal, wr_alm, wr_actl, wr_tctl;
  logic       aie, aflag, hit;
  logic       tie_q, tflag_q;
  cal_t       cal_q, cal_next;
  alm_t       alm_q;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_cal  = wr_en_i && (bank == 2'd0) && (addr_i != A_CTRL) && !busy && !advance;
  assign wr_alm  = wr_en_i && (bank == 2'd1) && (addr_i < ADDR_W'(N_ALM));
  assign wr_actl = wr_en_i && (bank == 2'd1) && (addr_i == A_FLAGS);
  assign wr_tctl = wr_en_i && (bank == 2'd2) && (addr_i == A_FLAGS);

  rtcn_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_i      (wr_ctrl),
    .wdata_i   (wdata_i),
    .bank_o    (bank),
    .stop_o    (stop),
    .busy_o    (busy),
    .advance_o (advance)
  );

  rtcn_calendar u_cal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .advance_i  (advance),
    .wr_i       (wr_cal),
    .waddr_i    (addr_i),
    .wdata_i    (wdata_i),
    .cal_o      (cal_q),
    .cal_next_o (cal_next)
  );

  rtcn_alarm u_alarm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .advance_i  (advance),
    .wr_reg_i   (wr_alm),
    .wr_ctl_i   (wr_actl),
    .waddr_i    (addr_i),
    .wdata_i    (wdata_i),
    .cal_next_i (cal_next),
    .alm_o      (alm_q),
    .aie_o      (aie),
    .aflag_o    (aflag),
    .hit_o      (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tie_q   <= 1'b0;
      tflag_q <= 1'b0;
    end else if (wr_tctl) begin
      tie_q   <= wdata_i[FB_EN];
      tflag_q <= wdata_i[FB_FLAG];
    end
  end

  assign irq_o = aflag && aie;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) begin
      rdata_o = {bank, stop, busy};
    end else begin
      case (bank)
        2'd0: rdata_o = cal_q[addr_i];
        2'd1: begin
          if (addr_i < ADDR_W'(N_ALM)) rdata_o = alm_q[addr_i];
          else if (addr_i == A_FLAGS) rdata_o = {2'b00, aflag, aie};
        end
        2'd2: if (addr_i == A_FLAGS) rdata_o = {2'b00, tflag_q, tie_q};
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/nibble_rtc_chk.sv
module nibble_rtc_chk
  import rtcn_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       advance,
  input logic       busy,
  input logic       stop,
  input logic       wr_cal,
  input logic       wr_ctrl,
  input logic       wr_actl,
  input logic       hit,
  input logic       aflag,
  input logic [1:0] bank,
  input logic [3:0] wdata_i,
  input cal_t       cal_q
);
  // R3: frozen while stopped unless the host loads a digit
  a_r3_stop_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !wr_cal) |=> $stable(cal_q));

  // R8: an advancing tick raises busy
  a_r8_busy_follows_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance |=> busy);

  // R8: busy never appears without an advance
  a_r8_busy_needs_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !advance) |=> !busy);

  // R9: host cannot touch the digits while busy
  a_r9_busy_blocks_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !advance) |=> $stable(cal_q));

  // R10: the flag only rises on an advancing tick with a match
  a_r10_flag_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aflag) |-> $past(advance && hit));

  // R11: the flag stays set until the alarm control is written
  a_r11_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aflag && !wr_actl) |=> aflag);

  // R12: bank select follows the control write
  a_r12_bank_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (bank == $past(wdata_i[3:2])));
endmodule

bind nibble_rtc nibble_rtc_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .advance (advance),
  .busy    (busy),
  .stop    (stop),
  .wr_cal  (wr_cal),
  .wr_ctrl (wr_ctrl),
  .wr_actl (wr_actl),
  .hit     (hit),
  .aflag   (aflag),
  .bank    (bank),
  .wdata_i (wdata_i),
  .cal_q   (cal_q)
);

// File: tb/nibble_rtc_tb.sv
module nibble_rtc_tb;
  localparam int BC = 4;

  logic       clk, rst_n, tick, wr_en, irq;
  logic [3:0] addr, wdata, rdata;

  int checks = 0;
  int errors = 0;

  // scoreboard queues (parallel)
  bit         q_irq[$];
  logic [3:0] q_exp[$];
  logic [3:0] q_adr[$];
  string      q_tag[$];

  // reference time model
  int m_sec, m_min, m_hr, m_wd, m_day, m_mon, m_yr;
  bit m_stop;

  nibble_rtc #(.BUSY_CYCLES(BC)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .addr_i  (addr),
    .wr_en_i (wr_en),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int mdays(int mo, int y);
    if (mo == 2) return (((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0)) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic m_step();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_wd = (m_wd + 1) % 7;
          m_day++;
          if (m_day > mdays(m_mon, m_yr)) begin
            m_day = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1;
              m_yr = (m_yr + 1) % 10000;
            end
          end
        end
      end
    end
  endtask

  function automatic logic [3:0] exp_digit(int a);
    case (a)
      0:  return 4'(m_sec % 10);
      1:  return 4'(m_sec / 10);
      2:  return 4'(m_min % 10);
      3:  return 4'(m_min / 10);
      4:  return 4'(m_hr % 10);
      5:  return 4'(m_hr / 10);
      6:  return 4'(m_wd);
      7:  return 4'(m_day % 10);
      8:  return 4'(m_day / 10);
      9:  return 4'(m_mon % 10);
      10: return 4'(m_mon / 10);
      11: return 4'(m_yr % 10);
      12: return 4'((m_yr / 10) % 10);
      13: return 4'((m_yr / 100) % 10);
      default: return 4'(m_yr / 1000);
    endcase
  endfunction

  // driver side: all tasks start and end on a falling edge
  task automatic rd_chk(input logic [3:0] a, input logic [3:0] e, input string tag);
    addr = a;
    q_irq.push_back(1'b0); q_exp.push_back(e); q_adr.push_back(a); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic irq_chk(input logic e, input string tag);
    q_irq.push_back(1'b1); q_exp.push_back({3'b000, e}); q_adr.push_back(4'h0); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctl(input logic [3:0] d);
    wr(4'hF, d);
    m_stop = d[1];
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (!m_stop) m_step();
  endtask

  task automatic idle();
    repeat (BC) @(negedge clk);
  endtask

  task automatic check_time(input string tag);
    for (int a = 0; a < 15; a++) rd_chk(4'(a), exp_digit(a), tag);
  endtask

  task automatic set_time(int s, int mi, int h, int wd, int d, int mo, int y);
    ctl(4'b0010);
    m_sec = s; m_min = mi; m_hr = h; m_wd = wd; m_day = d; m_mon = mo; m_yr = y;
    for (int a = 0; a < 15; a++) wr(4'(a), exp_digit(a));
    ctl(4'b0000);
  endtask

  // monitor: pops one expected item per cycle, 1 ns after the rising edge
  initial begin
    forever begin
      logic [3:0] got;
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        bit         k;
        logic [3:0] e, a;
        string      t;
        k = q_irq.pop_front(); e = q_exp.pop_front();
        a = q_adr.pop_front(); t = q_tag.pop_front();
        got = k ? {3'b000, irq} : rdata;
        checks++;
        if (got !== e) begin
          errors++;
          if (k) $display("FAIL %s: irq got %h expected %h", t, got, e);
          else   $display("FAIL %s: addr %h got %h expected %h", t, a, got, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; addr = 4'h0; wdata = 4'h0; m_stop = 1'b0;
    m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0; m_day = 1; m_mon = 1; m_yr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_time("R1");
    rd_chk(4'hF, 4'h0, "R1");
    irq_chk(1'b0, "R1");

    // R2 load while stopped, read back
    set_time(58, 59, 23, 6, 31, 12, 1999);
    check_time("R2");

    // R8 busy window after an advancing tick
    tick1();
    for (int i = 0; i < BC - 1; i++) rd_chk(4'hF, 4'b0001, "R8");
    rd_chk(4'hF, 4'b0000, "R8");
    rd_chk(4'h0, exp_digit(0), "R4");
    // R4 R5 R7 full rollover into the new year
    tick1(); idle();
    check_time("R5");
    rd_chk(4'h6, 4'd0, "R7");

    // R3 stop freezes time, no busy
    ctl(4'b0010);
    tick1();
    rd_chk(4'hF, 4'b0010, "R3");
    rd_chk(4'h0, exp_digit(0), "R3");
    ctl(4'b0000);

    // R6 leap cases
    set_time(59, 59, 23, 3, 28, 2, 2000); tick1(); idle(); check_time("R6");
    set_time(59, 59, 23, 3, 28, 2, 1900); tick1(); idle(); check_time("R6");
    set_time(59, 59, 23, 3, 28, 2, 2023); tick1(); idle(); check_time("R6");
    set_time(59, 59, 23, 4, 29, 2, 2024); tick1(); idle(); check_time("R6");
    // R5 30-day month, year wrap
    set_time(59, 59, 23, 5, 30, 4, 2021); tick1(); idle(); check_time("R5");
    set_time(59, 59, 23, 6, 31, 12, 9999); tick1(); idle(); check_time("R5");
    // R4 hour tens carry
    set_time(59, 59, 9, 1, 10, 3, 2022); tick1(); idle(); check_time("R4");

    // R9 write during busy dropped
    tick1();
    wr(4'h0, 4'h7);
    idle();
    check_time("R9");

    // R10 R11 alarm
    set_time(3, 34, 12, 2, 15, 6, 2021);
    ctl(4'b0100);
    wr(4'h0, 4'h5); wr(4'h1, 4'h0); wr(4'h2, 4'h0); wr(4'h3, 4'h8);
    wr(4'h4, 4'h0); wr(4'h5, 4'h8); wr(4'h6, 4'h8); wr(4'h7, 4'h0); wr(4'h8, 4'h8);
    wr(4'hE, 4'b0001);
    rd_chk(4'h3, 4'h8, "R10");
    tick1();
    irq_chk(1'b0, "R10");
    rd_chk(4'hE, 4'b0001, "R10");
    idle();
    tick1();
    irq_chk(1'b1, "R11");
    rd_chk(4'hE, 4'b0011, "R10");
    wr(4'hE, 4'b0011);
    rd_chk(4'hE, 4'b0011, "R11");
    wr(4'hE, 4'b0001);
    rd_chk(4'hE, 4'b0001, "R11");
    irq_chk(1'b0, "R11");
    // active minutes field blocks the match
    wr(4'h2, 4'h5); wr(4'h3, 4'h3); wr(4'h0, 4'h6);
    idle();
    tick1();
    rd_chk(4'hE, 4'b0001, "R10");
    // match with enable off: flag only
    wr(4'h3, 4'h8); wr(4'h0, 4'h7); wr(4'hE, 4'b0000);
    idle();
    tick1();
    rd_chk(4'hE, 4'b0010, "R11");
    irq_chk(1'b0, "R11");
    wr(4'hE, 4'b0011);
    irq_chk(1'b1, "R11");
    wr(4'hE, 4'b0000);
    rd_chk(4'hE, 4'b0000, "R11");
    irq_chk(1'b0, "R11");
    rd_chk(4'hF, 4'b0100, "R12");

    // R13 timer control and unmapped reads
    ctl(4'b1000);
    rd_chk(4'hF, 4'b1000, "R12");
    wr(4'hE, 4'b0011);
    rd_chk(4'hE, 4'b0011, "R13");
    wr(4'h0, 4'h9);
    rd_chk(4'h0, 4'h0, "R13");
    ctl(4'b1100);
    rd_chk(4'hE, 4'h0, "R13");
    rd_chk(4'hF, 4'b1100, "R12");
    ctl(4'b0100);
    rd_chk(4'hA, 4'h0, "R13");

    // R12 time untouched by other banks
    ctl(4'b0000);
    idle();
    check_time("R12");

    wait (q_exp.size() == 0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule